// File: doc/BRIEF.md
# 8-bit Timer/Counter with Prescaler

This block is an 8-bit up-counter that can count either instruction cycles or edges on an external clock pin. A single mode bit picks the source. In cycle mode the count path advances on each clock where the instruction-cycle strobe is high. That strobe may come every clock or every other clock. In edge mode the pin is first brought into the clock domain by two flops and then passed through an edge detector. A polarity bit selects whether rising or falling edges qualify.

An optional power-of-two prescaler sits in front of the counter. It divides by 2 up to 256, or it can be bypassed so that every qualifying event increments the counter. Software writes the count and a configuration register through plain write strobes and reads both back on output ports. When the counter wraps from 0xFF to 0x00, a one-clock overflow strobe is sent to an interrupt controller. Loading the count clears the prescaler and holds the counter still for the next two instruction cycles.

Top module: `tmr8_prescaled`

## Requirements
- R1: After reset the count reads 0x00, the configuration register reads 0x08 (cycle mode, rising edge, prescaler bypassed, ratio field 000) and the overflow strobe is low.
- R2: In cycle mode (config bit5 = 0) with the prescaler bypassed (config bit3 = 1), the count rises by one at each clock edge where the cycle strobe is high. It holds on every clock where the strobe is low, whether the strobe comes every clock or every other clock.
- R3: With the prescaler assigned (config bit3 = 0), the counter advances once per 2^(k+1) qualifying events, where k is config bits 2:0. So 000 divides by 2, 001 by 4 and 111 by 256.
- R4: In edge mode (config bit5 = 1) with rising polarity (config bit4 = 0), a rising edge on the pin, set up before a clock edge, changes the count at the third clock edge that follows. Falling edges have no effect.
- R5: In edge mode with falling polarity (config bit4 = 1), only falling pin edges advance the count, again at the third clock edge. Rising edges have no effect.
- R6: In edge mode the cycle strobe does not advance the count. In cycle mode the pin does not advance the count.
- R7: When the count wraps from 0xFF to 0x00, the overflow strobe is high for exactly the one clock in which the count first reads 0x00.
- R8: A count write loads the data at the next clock edge and clears the prescaler. Events during the next two cycle-strobe pulses after the write are discarded.
- R9: A configuration write stores bits 5:0. Config bits 7:6 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One pulse per instruction cycle |
| ext_pin | input | 1 | External count clock, asynchronous |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| opt_we | input | 1 | Configuration write strobe |
| opt_wdata | input | 8 | Configuration write data |
| cnt_q | output | 8 | Current count |
| opt_q | output | 8 | Current configuration |
| ovf_pulse | output | 1 | One-clock overflow strobe |

## Verification
Faults in the prescaler phase or in the post-write hold counter show up at the count port. The first increment then arrives one or more cycle strobes too early or too late, so the bench counts strobes exactly to the boundary and checks on both sides of it. A wrong synchroniser depth or edge polarity shows within three clocks of a pin transition, as a missing, early or spurious increment. An overflow strobe that is misplaced or stretched is visible in the clock where the count first reads zero and in the clock after it.

// File: rtl/tmr8_prescaled.sv
module tmr8_prescaled #(
  parameter int         CNT_W    = 8,
  parameter int         HOLD_CYC = 2,
  parameter logic [5:0] OPT_RST  = 6'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             ext_pin,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             opt_we,
  input  logic [7:0]       opt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [7:0]       opt_q,
  output logic             ovf_pulse
);
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 1 << SEL_W;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [5:0]       opt_r;
  logic [1:0]       sync_r;
  logic             pin_d;
  logic [PRE_W-1:0] pre_r;
  logic [HOLD_W-1:0] hold_r;
  logic [CNT_W-1:0] cnt_r;
  logic             ovf_r;

  wire              src_ext = opt_r[5];
  wire              fall    = opt_r[4];
  wire              bypass  = opt_r[3];
  wire [SEL_W-1:0]  sel     = opt_r[2:0];

  wire edge_hit = fall ? (pin_d & ~sync_r[1]) : (~pin_d & sync_r[1]);
  wire raw_evt  = src_ext ? edge_hit : cyc_tick;
  wire evt      = raw_evt && (hold_r == '0);

  wire [PRE_W-1:0] pre_mask = ~({PRE_W{1'b1}} << (32'(sel) + 1));
  wire             pre_full = (pre_r & pre_mask) == pre_mask;
  wire             inc      = evt && (bypass || pre_full);
  wire             wrap     = inc && (cnt_r == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_r  <= OPT_RST;
      sync_r <= '0;
      pin_d  <= 1'b0;
      pre_r  <= '0;
      hold_r <= '0;
      cnt_r  <= '0;
      ovf_r  <= 1'b0;
    end else begin
      sync_r <= {sync_r[0], ext_pin};
      pin_d  <= sync_r[1];
      if (opt_we) opt_r <= opt_wdata[5:0];
      ovf_r <= wrap && !cnt_we;
      if (cnt_we) begin
        cnt_r  <= cnt_wdata;
        pre_r  <= '0;
        hold_r <= HOLD_W'(HOLD_CYC);
      end else begin
        if (inc) cnt_r <= cnt_r + 1'b1;
        if (evt && !bypass) pre_r <= pre_full ? '0 : pre_r + 1'b1;
        if (cyc_tick && hold_r != '0) hold_r <= hold_r - 1'b1;
      end
    end
  end

  assign cnt_q     = cnt_r;
  assign opt_q     = {2'b00, opt_r};
  assign ovf_pulse = ovf_r;

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt_q == '0)); // R7
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R7
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata))); // R8
  AST_HOLD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_r != '0 && !cnt_we) |=> $stable(cnt_q)); // R8
  AST_OPT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q[7:6] == 2'b00); // R9
endmodule

// File: tb/tmr8_prescaled_bench.sv
module tmr8_prescaled_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_tick = 1'b0, ext_pin = 1'b0, cnt_we = 1'b0, opt_we = 1'b0;
  logic [7:0] cnt_wdata = '0, opt_wdata = '0;
  logic [7:0] cnt_q, opt_q;
  logic ovf_pulse;
  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  tmr8_prescaled u_tmr8_prescaled (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .opt_we(opt_we), .opt_wdata(opt_wdata),
    .cnt_q(cnt_q), .opt_q(opt_q), .ovf_pulse(ovf_pulse));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cyc_tick = 1'b1;
    repeat (n) @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] d);
    cnt_we = 1'b1; cnt_wdata = d;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic wr_opt(input logic [7:0] d);
    opt_we = 1'b1; opt_wdata = d;
    @(negedge clk);
    opt_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", cnt_q, 8'h00);
    chk("R1 config", opt_q, 8'h08);
    chk("R1 ovf", ovf_pulse, 0);
  endtask

  task automatic t_timer_bypass;
    wr_opt(8'h08);
    wr_cnt(8'h00);
    ticks(2);
    chk("R8 hold", cnt_q, 8'h00);
    ticks(3);
    chk("R2 back-to-back", cnt_q, 8'h03);
    for (int i = 0; i < 5; i++) begin
      cyc_tick = 1'b1; @(negedge clk);
      cyc_tick = 1'b0; @(negedge clk);
    end
    chk("R2 two-clock cycles", cnt_q, 8'h08);
    idle(4);
    chk("R2 no strobe", cnt_q, 8'h08);
    for (int i = 0; i < 4; i++) begin
      ext_pin = ~ext_pin; idle(4);
    end
    chk("R6 pin ignored in cycle mode", cnt_q, 8'h08);
  endtask

  task automatic t_prescale(input int k);
    int n;
    n = 2 << k;
    wr_opt(8'(k));
    wr_cnt(8'h00);
    ticks(2);
    ticks(n - 1);
    chk($sformatf("R3 ratio %0d below", n), cnt_q, 8'h00);
    ticks(1);
    chk($sformatf("R3 ratio %0d first", n), cnt_q, 8'h01);
    ticks(n);
    chk($sformatf("R3 ratio %0d second", n), cnt_q, 8'h02);
  endtask

  task automatic t_write_clears;
    wr_opt(8'h01);
    wr_cnt(8'h00);
    ticks(2);
    ticks(2);
    wr_cnt(8'h10);
    chk("R8 load", cnt_q, 8'h10);
    ticks(2);
    ticks(3);
    chk("R8 prescaler cleared", cnt_q, 8'h10);
    ticks(1);
    chk("R8 first after clear", cnt_q, 8'h11);
    wr_opt(8'h08);
    wr_cnt(8'h40);
    ticks(1);
    chk("R8 first strobe held", cnt_q, 8'h40);
    ticks(1);
    chk("R8 second strobe held", cnt_q, 8'h40);
    ticks(1);
    chk("R8 third strobe counts", cnt_q, 8'h41);
  endtask

  task automatic t_edge_rise;
    ext_pin = 1'b0;
    wr_opt(8'h28);
    wr_cnt(8'h00);
    ticks(2);
    idle(3);
    ext_pin = 1'b1;
    idle(2);
    chk("R4 not before third edge", cnt_q, 8'h00);
    idle(1);
    chk("R4 rise counted", cnt_q, 8'h01);
    ext_pin = 1'b0;
    idle(5);
    chk("R4 fall ignored", cnt_q, 8'h01);
    ticks(6);
    chk("R6 strobe ignored in edge mode", cnt_q, 8'h01);
  endtask

  task automatic t_edge_fall;
    wr_opt(8'h38);
    wr_cnt(8'h00);
    ticks(2);
    idle(3);
    ext_pin = 1'b1;
    idle(5);
    chk("R5 rise ignored", cnt_q, 8'h00);
    ext_pin = 1'b0;
    idle(2);
    chk("R5 not before third edge", cnt_q, 8'h00);
    idle(1);
    chk("R5 fall counted", cnt_q, 8'h01);
  endtask

  task automatic t_overflow;
    wr_opt(8'h08);
    wr_cnt(8'hFE);
    ticks(2);
    ticks(1);
    chk("R7 at FF", cnt_q, 8'hFF);
    chk("R7 no early strobe", ovf_pulse, 0);
    ticks(1);
    chk("R7 wrapped", cnt_q, 8'h00);
    chk("R7 strobe high", ovf_pulse, 1);
    idle(1);
    chk("R7 strobe one clock", ovf_pulse, 0);
  endtask

  task automatic t_config;
    wr_opt(8'hFF);
    chk("R9 top bits zero", opt_q, 8'h3F);
    wr_opt(8'h15);
    chk("R9 readback", opt_q, 8'h15);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_timer_bypass();
    t_prescale(0);
    t_prescale(1);
    t_prescale(7);
    t_write_clears();
    t_edge_rise();
    t_edge_fall();
    t_overflow();
    t_config();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule